// File: doc/BRIEF.md
# Per-Application Shadow Tag Monitor

This block measures, for each of several applications sharing one last-level cache, the hit and miss behaviour each application would see if it had a cache to itself. Two capacities are modelled at the same time: a large one (4 MB, 16 ways, 4096 sets) and a small one (512 KB, 8 ways, 1024 sets). Each application owns one directory per capacity. A directory holds tags and replacement state only and never stores data.

Storage and lookup traffic are reduced by set sampling. Only accesses whose large-cache set index has its low `SAMPLE_LOG` bits at zero are tracked. With the default of 1 in 256, that leaves 16 large sets and 4 small sets per directory. The small capacity uses the same sampling decision. Accesses arrive at most one per cycle on a valid/application/address interface.

A tracked access is looked up on the cycle after it is accepted. Its hit or miss is counted on the cycle after that. Software reads the saturating counters directly from the output buses. A synchronous clear zeroes every counter and empties every directory.

Top module: `shadow_tag_monitor`

## Requirements
- R1: An access whose address bits [13:6] are not all zero (an unsampled set) changes no counter and no directory contents.
- R2: The address is split with a 64-byte line. For the large capacity, the set is bits [17:6] and the tag is bits [31:18]. For the small capacity, the set is bits [15:6] and the tag is bits [31:16]. A first access to a line counts a miss on both capacities, and a later access anywhere in the same line counts a hit.
- R3: Each application has private directories. An access by one application never hits or evicts another application's entries.
- R4: The large capacity holds 16 lines per set and the small capacity holds 8. When a ninth distinct line maps to one small set, the small directory evicts a line while the large directory still holds it.
- R5: Replacement is true LRU. A hit makes its way most recently used. A miss fills the lowest-numbered invalid way if there is one, otherwise the least recently used way.
- R6: An access presented before clock edge N changes its counter at edge N+2, and the counter is unchanged at edges N and N+1.
- R7: Counters are `CNT_W` bits wide (32 by default) and hold at their maximum value instead of wrapping.
- R8: While `clear_i` is sampled high, all counters go to zero, all directory entries become invalid, and the in-flight access is dropped.
- R9: After reset, every counter reads zero and every directory is empty.
- R10: Accesses on consecutive cycles are all counted. A second access to a line, issued on the cycle right after the access that filled it, counts as a hit.
- R11: Counter slot k occupies bits [k*CNT_W +: CNT_W] of each count bus, with k = app*2 + cap, where cap 0 is large and cap 1 is small.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of counters and directories |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_app_i | input | APP_W | Application identifier of the access |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| hit_count_o | output | NUM_APPS*2*CNT_W | Hit counters, one slot per (application, capacity) |
| miss_count_o | output | NUM_APPS*2*CNT_W | Miss counters, one slot per (application, capacity) |

## Verification
Some properties are checked by assertions on every cycle:
- After each lookup, the way just touched is valid and has age zero.
- At most one application's directory responds for each capacity.
- No counter ever decreases without a clear.

The bench's directed scenarios cover what a single cycle cannot show:
- eviction order under LRU and the capacity difference between the two sizes,
- isolation between applications,
- the exact counting latency,
- back-to-back hits,
- saturation, which the bench reaches by overriding the counter width.

// File: rtl/shadow_pkg.sv
// Shared definitions for the shadow tag monitor.
// Assumes two modelled capacities per application.
package shadow_pkg;
    typedef enum logic {CAP_BIG = 1'b0, CAP_SMALL = 1'b1} cap_e;
    localparam int NUM_CAPS = 2;

    // Counter slot for an (application, capacity) pair.
    function automatic int cnt_slot(input int app, input int cap);
        return app * NUM_CAPS + cap;
    endfunction
endpackage

// File: rtl/sat_counter.sv
// Saturating event counter with synchronous clear.
// Assumes at most one increment per cycle.
module sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] MAX_V = '1;

    // Count events, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            count_o <= '0;
        else if (inc_i && count_o != MAX_V)
            count_o <= count_o + 1'b1;
    end

    // R7: the counter never wraps and never loses value without a clear.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> count_o >= $past(count_o));
endmodule

// File: rtl/shadow_dir.sv
// Tag-only set-associative directory with true-LRU replacement via per-way ages.
// Assumes WAYS is a power of two. req_i is a lookup for set_i/tag_i this cycle;
// the result is returned one cycle later as a one-cycle hit_o or miss_o pulse.
module shadow_dir #(
    parameter int SETS  = 16,
    parameter int WAYS  = 16,
    parameter int TAG_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 req_i,
    input  logic [SET_W-1:0]     set_i,
    input  logic [TAG_W-1:0]     tag_i,
    output logic                 hit_o,
    output logic                 miss_o
);
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    logic             hit;
    logic             any_inv;
    logic [WAY_W-1:0] hit_way, inv_way, lru_way, sel_way, sel_age;
    logic             last_v;
    logic [SET_W-1:0] last_set;
    logic [WAY_W-1:0] last_way;

    // Find the hitting way, the lowest invalid way and the oldest way.
    always_comb begin
        hit     = 1'b0;
        any_inv = 1'b0;
        hit_way = '0;
        inv_way = '0;
        lru_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vld_q[set_i][w] && tag_q[set_i][w] == tag_i) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!vld_q[set_i][w]) begin
                any_inv = 1'b1;
                inv_way = WAY_W'(w);
            end
            if (age_q[set_i][w] == OLDEST)
                lru_way = WAY_W'(w);
        end
        sel_way = hit ? hit_way : (any_inv ? inv_way : lru_way);
        sel_age = age_q[set_i][sel_way];
    end

    // Valid bits, LRU ages and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
            end
            hit_o    <= 1'b0;
            miss_o   <= 1'b0;
            last_v   <= 1'b0;
            last_set <= '0;
            last_way <= '0;
        end else begin
            hit_o    <= req_i && hit;
            miss_o   <= req_i && !hit;
            last_v   <= req_i;
            last_set <= set_i;
            last_way <= sel_way;
            if (req_i) begin
                vld_q[set_i][sel_way] <= 1'b1;
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == sel_way)
                        age_q[set_i][w] <= '0;
                    else if (age_q[set_i][w] < sel_age)
                        age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
                end
            end
        end
    end

    // Tag storage, written on a miss fill only.
    always_ff @(posedge clk) begin
        if (rst_n && !clr_i && req_i && !hit)
            tag_q[set_i][sel_way] <= tag_i;
    end

    // R5: the way touched by the last lookup is now most recently used.
    p_mru_after_touch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last_v |-> age_q[last_set][last_way] == '0);
    // R2: a looked-up line is resident afterwards.
    p_line_resident_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_v |-> vld_q[last_set][last_way]);
    // R2: a lookup yields exactly one of hit or miss.
    p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_v |-> (hit_o ^ miss_o));
endmodule

// File: rtl/shadow_tag_monitor.sv
// Per-application shadow tag monitor: samples sets of an access stream and
// models each application alone on a large and a small cache, counting hits
// and misses. Assumes at most one access per cycle. Latency: stage 1 registers
// the access, stage 2 looks up and updates, stage 3 counts.
module shadow_tag_monitor
    import shadow_pkg::*;
#(
    parameter int NUM_APPS      = 2,
    parameter int APP_W         = 1,
    parameter int ADDR_W        = 32,
    parameter int LINE_LOG      = 6,
    parameter int BIG_SET_LOG   = 12,
    parameter int BIG_WAYS      = 16,
    parameter int SMALL_SET_LOG = 10,
    parameter int SMALL_WAYS    = 8,
    parameter int SAMPLE_LOG    = 8,
    parameter int CNT_W         = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear_i,
    input  logic                             acc_valid_i,
    input  logic [APP_W-1:0]                 acc_app_i,
    input  logic [ADDR_W-1:0]                acc_addr_i,
    output logic [NUM_APPS*2*CNT_W-1:0]      hit_count_o,
    output logic [NUM_APPS*2*CNT_W-1:0]      miss_count_o
);
    localparam int NUM_CNT     = NUM_APPS * NUM_CAPS;
    localparam int BIG_SETS    = 1 << (BIG_SET_LOG - SAMPLE_LOG);
    localparam int SMALL_SETS  = 1 << (SMALL_SET_LOG - SAMPLE_LOG);
    localparam int BIG_SW      = (BIG_SETS > 1) ? $clog2(BIG_SETS) : 1;
    localparam int SMALL_SW    = (SMALL_SETS > 1) ? $clog2(SMALL_SETS) : 1;
    localparam int BIG_TAG_W   = ADDR_W - LINE_LOG - BIG_SET_LOG;
    localparam int SMALL_TAG_W = ADDR_W - LINE_LOG - SMALL_SET_LOG;
    localparam int SAMP_LSB    = LINE_LOG + SAMPLE_LOG;

    logic                   sampled;
    logic                   s1_valid;
    logic [APP_W-1:0]       s1_app;
    logic [BIG_SW-1:0]      s1_big_set;
    logic [SMALL_SW-1:0]    s1_small_set;
    logic [BIG_TAG_W-1:0]   s1_big_tag;
    logic [SMALL_TAG_W-1:0] s1_small_tag;
    logic [NUM_CNT-1:0]     hit_p, miss_p;
    logic [NUM_APPS-1:0]    big_resp, small_resp;

    // Sampling filter: tracked when the low large-index bits are zero.
    always_comb sampled = (acc_addr_i[LINE_LOG +: SAMPLE_LOG] == '0)
                          && (int'(acc_app_i) < NUM_APPS);

    // Stage 1: register the sampled access and split its address.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            s1_valid     <= 1'b0;
            s1_app       <= '0;
            s1_big_set   <= '0;
            s1_small_set <= '0;
            s1_big_tag   <= '0;
            s1_small_tag <= '0;
        end else begin
            s1_valid     <= acc_valid_i && sampled;
            s1_app       <= acc_app_i;
            s1_big_set   <= BIG_SW'(acc_addr_i[SAMP_LSB +: BIG_SW]);
            s1_small_set <= SMALL_SW'(acc_addr_i[SAMP_LSB +: SMALL_SW]);
            s1_big_tag   <= acc_addr_i[ADDR_W-1 -: BIG_TAG_W];
            s1_small_tag <= acc_addr_i[ADDR_W-1 -: SMALL_TAG_W];
        end
    end

    // Stage 2: one pair of private directories per application.
    for (genvar a = 0; a < NUM_APPS; a++) begin : g_app
        logic req;
        always_comb req = s1_valid && (int'(s1_app) == a);

        shadow_dir #(.SETS(BIG_SETS), .WAYS(BIG_WAYS), .TAG_W(BIG_TAG_W)) u_big (
            .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .req_i(req),
            .set_i(s1_big_set), .tag_i(s1_big_tag),
            .hit_o(hit_p[cnt_slot(a, CAP_BIG)]),
            .miss_o(miss_p[cnt_slot(a, CAP_BIG)]));

        shadow_dir #(.SETS(SMALL_SETS), .WAYS(SMALL_WAYS), .TAG_W(SMALL_TAG_W)) u_small (
            .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .req_i(req),
            .set_i(s1_small_set), .tag_i(s1_small_tag),
            .hit_o(hit_p[cnt_slot(a, CAP_SMALL)]),
            .miss_o(miss_p[cnt_slot(a, CAP_SMALL)]));

        always_comb begin
            big_resp[a]   = hit_p[cnt_slot(a, CAP_BIG)]   | miss_p[cnt_slot(a, CAP_BIG)];
            small_resp[a] = hit_p[cnt_slot(a, CAP_SMALL)] | miss_p[cnt_slot(a, CAP_SMALL)];
        end
    end

    // Stage 3: saturating hit and miss counters per slot.
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        sat_counter #(.W(CNT_W)) u_hit (
            .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .inc_i(hit_p[k]),
            .count_o(hit_count_o[k*CNT_W +: CNT_W]));
        sat_counter #(.W(CNT_W)) u_miss (
            .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .inc_i(miss_p[k]),
            .count_o(miss_count_o[k*CNT_W +: CNT_W]));
    end

    // R3: only one application's directories respond to any access.
    p_app_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(big_resp) <= 1 && $countones(small_resp) <= 1);
    // R2: both capacities respond to the same access together.
    p_caps_in_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        big_resp == small_resp);
    // R1: an unsampled access never reaches stage 1.
    p_unsampled_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_addr_i[LINE_LOG +: SAMPLE_LOG] != '0) |=> !s1_valid);
endmodule

// File: tb/shadow_tag_monitor_test.sv
`timescale 1ns/1ps
module shadow_tag_monitor_test;
    localparam int CW = 4;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 1'b0;
    logic acc_valid_i = 1'b0;
    logic [0:0] acc_app_i = '0;
    logic [31:0] acc_addr_i = '0;
    logic [NC*CW-1:0] hit_count_o, miss_count_o;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    shadow_tag_monitor #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .acc_valid_i(acc_valid_i), .acc_app_i(acc_app_i), .acc_addr_i(acc_addr_i),
        .hit_count_o(hit_count_o), .miss_count_o(miss_count_o));

    // Line k of large set 0 / small set 0 (sampled, distinct tags).
    function automatic logic [31:0] line(input int k);
        return 32'(k) << 18;
    endfunction
    function automatic int hits(input int slot);
        return int'(hit_count_o[slot*CW +: CW]);
    endfunction
    function automatic int misses(input int slot);
        return int'(miss_count_o[slot*CW +: CW]);
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic acc(input int app, input logic [31:0] addr);
        @(negedge clk);
        acc_valid_i = 1'b1; acc_app_i = 1'(app); acc_addr_i = addr;
        @(negedge clk);
        acc_valid_i = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
    endtask

    task automatic t_reset();
        for (int k = 0; k < NC; k++) begin
            chk("R9 reset hit", hits(k), 0);
            chk("R9 reset miss", misses(k), 0);
        end
    endtask

    task automatic t_unsampled();
        do_clear();
        acc(0, 32'h0000_0040);
        acc(1, 32'h0000_2000);
        acc(0, line(3) | 32'h0000_1000);
        settle();
        for (int k = 0; k < NC; k++) chk("R1 unsampled", hits(k) + misses(k), 0);
    endtask

    task automatic t_basic();
        do_clear();
        acc(0, line(5) | 32'h0000_C000);
        settle();
        chk("R2 first miss big", misses(0), 1);
        chk("R2 first miss small", misses(1), 1);
        acc(0, line(5) | 32'h0000_C008);
        settle();
        chk("R2 same line hit big", hits(0), 1);
        chk("R11 same line hit small slot", hits(1), 1);
    endtask

    task automatic t_isolate();
        do_clear();
        acc(0, line(2));
        acc(1, line(2));
        settle();
        chk("R3 other app misses big", misses(2), 1);
        chk("R3 other app misses small", misses(3), 1);
        chk("R3 no hit for app0", hits(0), 0);
        acc(0, line(2));
        settle();
        chk("R3 app0 entry kept", hits(0), 1);
    endtask

    task automatic t_capacity();
        do_clear();
        for (int k = 0; k < 9; k++) acc(0, line(k));
        acc(0, line(0));
        settle();
        chk("R4 big keeps 9th line", hits(0), 1);
        chk("R4 small evicted", misses(1), 10);
        chk("R4 small no hit", hits(1), 0);
    endtask

    task automatic t_lru();
        do_clear();
        for (int k = 0; k < 8; k++) acc(0, line(k));
        acc(0, line(0));
        acc(0, line(8));
        acc(0, line(0));
        settle();
        chk("R5 refreshed line survives", hits(1), 2);
        acc(0, line(1));
        settle();
        chk("R5 LRU line evicted", misses(1), 10);
        chk("R5 big still holds", hits(0), 3);
    endtask

    task automatic t_latency();
        do_clear();
        @(negedge clk);
        acc_valid_i = 1'b1; acc_app_i = 1'b1; acc_addr_i = line(7);
        @(negedge clk);
        acc_valid_i = 1'b0;
        chk("R6 unchanged after edge N", misses(2), 0);
        @(negedge clk);
        chk("R6 unchanged after edge N+1", misses(2), 0);
        @(negedge clk);
        chk("R6 counted at edge N+2", misses(2), 1);
    endtask

    task automatic t_saturate();
        do_clear();
        for (int k = 0; k < 18; k++) acc(0, line(4));
        settle();
        chk("R7 hit saturates", hits(0), 15);
        chk("R7 miss once", misses(0), 1);
    endtask

    task automatic t_clear();
        do_clear();
        acc(0, line(6));
        settle();
        do_clear();
        chk("R8 counters zeroed", misses(0), 0);
        acc(0, line(6));
        settle();
        chk("R8 tags invalidated", misses(0), 1);
        chk("R8 no stale hit", hits(0), 0);
    endtask

    task automatic t_back_to_back();
        do_clear();
        @(negedge clk);
        acc_valid_i = 1'b1; acc_app_i = 1'b0; acc_addr_i = line(9);
        @(negedge clk);
        acc_addr_i = line(9) | 32'h4;
        @(negedge clk);
        acc_addr_i = line(9) | 32'h0000_4000;
        @(negedge clk);
        acc_valid_i = 1'b0;
        settle();
        chk("R10 b2b misses big", misses(0), 2);
        chk("R10 b2b hit big", hits(0), 1);
        chk("R10 b2b hit small", hits(1), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsampled();
        t_basic();
        t_isolate();
        t_capacity();
        t_lru();
        t_latency();
        t_saturate();
        t_clear();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule